// File: doc/BRIEF.md
# Chainable Serial Gain Control Port

This block is the serial control port of a gain-setting peripheral. A host writes a 16-bit control word over a four-wire SPI link (active-low select, serial clock, data in, data out). The word passes through a 16-bit shift register. Bits that leave the far end of that register are driven on the data output, so several ports can be wired in a chain, or can share one MISO line through the output-enable.

Nothing changes on the control outputs while bits are being shifted. When the select line returns high, the word currently in the shift register is split into its fields. Those fields are a 5-bit gain code, a gain-mode bit, a GPO-mode bit and four general-purpose outputs, and they are held until the next transfer completes.

The port runs on a fast system clock. It treats all three serial inputs as asynchronous. Each input passes through a two-stage synchronizer, and edges are detected on the synchronized copies. For this reason the system clock must be at least four times the serial clock.

Top module: `gain_cfg_port`

## Requirements
- R1: The control outputs change only after the select line rises (a low-to-high transition ends a transfer). While a transfer is in progress the control outputs keep the values of the previous transfer.
- R2: While the select line is high, serial clock edges have no effect on the shift register or on the control outputs.
- R3: The data input is sampled on each rising serial clock edge while select is low and shifted into bit 0, most significant bit first. The latched word decodes as follows:
  - gain code = bits 12..8
  - gain-mode = bit 4
  - GPO-mode = bit 5
  - GPO outputs = bits 3..0
- R4: Reserved bits 15..13, 7 and 6 have no effect on any control output.
- R5: At the falling edge of select, the data output shows bit 15 of the shift register. It then updates on each falling serial clock edge to the bit leaving the register. A bit therefore reappears on the data output exactly 16 serial clocks after it entered.
- R6: The data output enable is low while select is high and high while select is low, after at most four system clock cycles.
- R7: If a transfer carries a bit count other than 16, the last 16 bits received are the ones latched. This includes 32 bits for two chained ports.
- R8: Reset clears the shift register and all control outputs to zero and drives the output enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low transfer select |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out (bit leaving the shift register) |
| dout_oe_o | output | 1 | Output enable for the data-out pad driver |
| gain_o | output | 5 | Latched gain code |
| gain_mode_o | output | 1 | Latched gain-mode bit |
| gpo_mode_o | output | 1 | Latched GPO-mode bit |
| gpo_o | output | 4 | Latched general-purpose outputs |

## Verification
The bound checker verifies the following on every cycle:
- The control outputs hold still unless a synchronized select rise was detected.
- The shift register is frozen while select is high, and shifts by exactly one place with the sampled bit on each qualified clock edge.
- The data output moves only on a serial clock fall or a select fall.
- The enable follows a select level that has been steady for four cycles.

The field mapping, the treatment of reserved bits, the 16-clock pass-through delay seen by a chained neighbour, the latching of the last 16 bits after an odd-length transfer, and the cleared state after reset are shown only by the bench's transfers.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  localparam int WORD_W     = 16;
  localparam int GAIN_W     = 5;
  localparam int GPO_W      = 4;
  localparam int GAIN_LSB   = 8;
  localparam int GPO_LSB    = 0;
  localparam int GAINMD_POS = 4;
  localparam int GPOMD_POS  = 5;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic              gain_mode;
    logic              gpo_mode;
    logic [GPO_W-1:0]  gpo;
  } cfg_t;

  function automatic cfg_t split_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.gain      = w[GAIN_LSB +: GAIN_W];
    c.gain_mode = w[GAINMD_POS];
    c.gpo_mode  = w[GPOMD_POS];
    c.gpo       = w[GPO_LSB +: GPO_W];
    return c;
  endfunction
endpackage

// File: rtl/gcp_sync.sv
module gcp_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gcp_front.sv
module gcp_front #(
  parameter int STAGES = gcp_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic din_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_act_o,
  output logic din_o
);
  localparam int NSIG = 3;
  localparam int IDX_SCLK = 0;
  localparam int IDX_CS   = 1;
  localparam int IDX_DIN  = 2;
  localparam logic [NSIG-1:0] IDLE = NSIG'(1) << IDX_CS;

  logic [NSIG-1:0] raw, synced;
  logic sclk_q, sclk_d, cs_q, cs_d;

  assign raw[IDX_SCLK] = sclk_i;
  assign raw[IDX_CS]   = cs_n_i;
  assign raw[IDX_DIN]  = din_i;

  gcp_sync #(.WIDTH(NSIG), .STAGES(STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  always_comb begin
    sclk_d = synced[IDX_SCLK];
    cs_d   = synced[IDX_CS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
    end
  end

  assign sclk_rise_o = synced[IDX_SCLK] & ~sclk_q;
  assign sclk_fall_o = ~synced[IDX_SCLK] & sclk_q;
  assign cs_fall_o   = ~synced[IDX_CS] & cs_q;
  assign cs_rise_o   = synced[IDX_CS] & ~cs_q;
  assign cs_act_o    = ~synced[IDX_CS];
  assign din_o       = synced[IDX_DIN];
endmodule

// File: rtl/gcp_shifter.sv
module gcp_shifter #(
  parameter int WORD_W = gcp_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              cs_fall_i,
  input  logic              shift_i,
  input  logic              drive_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] sr_o,
  output logic              dout_o,
  output logic              oe_o
);
  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] sr_q, sr_d;
  logic dout_q, dout_d, oe_q, oe_d;

  always_comb begin
    sr_d   = sr_q;
    dout_d = dout_q;
    oe_d   = cs_act_i;
    if (cs_act_i && shift_i) sr_d = {sr_q[MSB-1:0], din_i};
    if (cs_fall_i)                dout_d = sr_q[MSB];
    else if (cs_act_i && drive_i) dout_d = sr_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      dout_q <= dout_d;
      oe_q   <= oe_d;
    end
  end

  assign sr_o   = sr_q;
  assign dout_o = dout_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/gcp_hold.sv
module gcp_hold #(
  parameter int WORD_W = gcp_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output gcp_pkg::cfg_t     cfg_o
);
  gcp_pkg::cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load_i) cfg_d = gcp_pkg::split_word(word_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/gain_cfg_port.sv
module gain_cfg_port #(
  parameter int WORD_W = gcp_pkg::WORD_W,
  parameter int GAIN_W = gcp_pkg::GAIN_W,
  parameter int GPO_W  = gcp_pkg::GPO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              gain_mode_o,
  output logic              gpo_mode_o,
  output logic [GPO_W-1:0]  gpo_o
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic rst_core_n;
  logic sclk_rise_w, sclk_fall_w, cs_fall_w, cs_rise_w, cs_act_w, din_w;
  logic [WORD_W-1:0] sr_w;
  gcp_pkg::cfg_t cfg_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[RST_STAGES-1];

  gcp_front u_front (
    .clk(clk), .rst_n(rst_core_n),
    .sclk_i(sclk_i), .cs_n_i(cs_n_i), .din_i(din_i),
    .sclk_rise_o(sclk_rise_w), .sclk_fall_o(sclk_fall_w),
    .cs_fall_o(cs_fall_w), .cs_rise_o(cs_rise_w),
    .cs_act_o(cs_act_w), .din_o(din_w)
  );

  gcp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_core_n),
    .cs_act_i(cs_act_w), .cs_fall_i(cs_fall_w),
    .shift_i(sclk_rise_w), .drive_i(sclk_fall_w), .din_i(din_w),
    .sr_o(sr_w), .dout_o(dout_o), .oe_o(dout_oe_o)
  );

  gcp_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_core_n),
    .load_i(cs_rise_w), .word_i(sr_w), .cfg_o(cfg_w)
  );

  assign gain_o      = cfg_w.gain;
  assign gain_mode_o = cfg_w.gain_mode;
  assign gpo_mode_o  = cfg_w.gpo_mode;
  assign gpo_o       = cfg_w.gpo;
endmodule

// File: rtl/gcp_checker.sv
module gcp_checker #(
  parameter int WORD_W = 16,
  parameter int GAIN_W = 5,
  parameter int GPO_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_i,
  input logic              cs_rise,
  input logic              cs_fall,
  input logic              cs_act,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              din_s,
  input logic [WORD_W-1:0] sr,
  input logic              dout,
  input logic              oe,
  input logic [GAIN_W-1:0] gain,
  input logic              gain_mode,
  input logic              gpo_mode,
  input logic [GPO_W-1:0]  gpo
);
  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 7) cyc <= cyc + 3'd1;
  end

  // R1: control outputs move only after a detected select rise
  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && !cs_rise) |=> ($stable(gain) && $stable(gain_mode) &&
                                $stable(gpo_mode) && $stable(gpo)));

  // R2: no shifting while select is high
  assert_frozen_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && !cs_act) |=> $stable(sr));

  // R3: a qualified rising edge shifts one place with the sampled bit
  assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && cs_act && sclk_rise) |=>
      (sr[0] == $past(din_s) && sr[WORD_W-1:1] == $past(sr[WORD_W-2:0])));

  // R5: data output moves only on a serial clock fall or a select fall
  assert_dout_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && !sclk_fall && !cs_fall) |=> $stable(dout));

  // R6: enable tracks a select level steady for four cycles
  assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 5 && cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)
     && $past(cs_n_i, 4)) |-> !oe);
  assert_oe_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 5 && !cs_n_i && !$past(cs_n_i) && !$past(cs_n_i, 2) && !$past(cs_n_i, 3)
     && !$past(cs_n_i, 4)) |-> oe);
endmodule

bind gain_cfg_port gcp_checker #(.WORD_W(WORD_W), .GAIN_W(GAIN_W), .GPO_W(GPO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i),
  .cs_rise(cs_rise_w), .cs_fall(cs_fall_w), .cs_act(cs_act_w),
  .sclk_rise(sclk_rise_w), .sclk_fall(sclk_fall_w), .din_s(din_w),
  .sr(sr_w), .dout(dout_o), .oe(dout_oe_o),
  .gain(gain_o), .gain_mode(gain_mode_o), .gpo_mode(gpo_mode_o), .gpo(gpo_o)
);

// File: tb/gain_cfg_port_bench.sv
module gain_cfg_port_bench;
  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, din;
  logic dout, oe, gm, pm;
  logic [4:0] gain;
  logic [3:0] gpo;
  logic [63:0] seen;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gain_cfg_port u_gain_cfg_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
    .dout_o(dout), .dout_oe_o(oe), .gain_o(gain), .gain_mode_o(gm),
    .gpo_mode_o(pm), .gpo_o(gpo)
  );

  typedef struct packed {
    logic [15:0] w;
    logic [4:0]  g;
    logic        gmx;
    logic        pmx;
    logic [3:0]  o;
  } vec_t;

  // R3 field mapping; last entry sets reserved bits (R4)
  localparam vec_t VECS [5] = '{
    '{16'h1F3F, 5'h1F, 1'b1, 1'b1, 4'hF},
    '{16'h0A25, 5'h0A, 1'b0, 1'b1, 4'h5},
    '{16'h1510, 5'h15, 1'b1, 1'b0, 4'h0},
    '{16'h0000, 5'h00, 1'b0, 1'b0, 4'h0},
    '{16'hE0C9, 5'h00, 1'b0, 1'b0, 4'h9}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(input string tag, input logic [4:0] g, input logic a,
                         input logic b, input logic [3:0] o);
    chk({tag, " gain"}, 64'(gain), 64'(g));
    chk({tag, " gain_mode"}, 64'(gm), 64'(a));
    chk({tag, " gpo_mode"}, 64'(pm), 64'(b));
    chk({tag, " gpo"}, 64'(gpo), 64'(o));
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    seen = '0;
    #40;
  endtask

  task automatic send(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = v[i];
      #20;
      sclk = 1'b1;
      seen = {seen[62:0], dout};
      #40;
      sclk = 1'b0;
      #20;
    end
  endtask

  task automatic cs_high();
    #20;
    cs_n = 1'b1;
    #100;
  endtask

  task automatic xfer(input logic [63:0] v, input int n);
    cs_low();
    send(v, n);
    cs_high();
  endtask

  initial begin
    #400us;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
    repeat (10) @(negedge clk);
    chk_cfg("R8 reset", 5'h0, 1'b0, 1'b0, 4'h0);
    chk("R8 reset oe", 64'(oe), 64'h0);
    chk("R6 oe idle after reset", 64'(oe), 64'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    prev = 16'h0000;
    for (int k = 0; k < 5; k++) begin
      xfer(64'(VECS[k].w), 16);
      chk((k == 0) ? "R8 cleared shift reg on dout" : "R5 pass-through",
          seen[15:0], 64'(prev));
      chk_cfg((k == 4) ? "R4 reserved" : "R3 fields",
              VECS[k].g, VECS[k].gmx, VECS[k].pmx, VECS[k].o);
      prev = VECS[k].w;
    end

    xfer(64'h1F3F, 16);
    chk("R5 pass-through prior word", seen[15:0], 64'hE0C9);
    chk_cfg("R3 1F3F", 5'h1F, 1'b1, 1'b1, 4'hF);

    // R1: outputs unchanged mid-transfer
    cs_low();
    send(64'h0A, 8);
    chk_cfg("R1 mid-transfer", 5'h1F, 1'b1, 1'b1, 4'hF);
    chk("R6 oe active", 64'(oe), 64'h1);
    send(64'h25, 8);
    cs_high();
    chk("R5 pass-through split", seen[15:0], 64'h1F3F);
    chk_cfg("R1 after rise", 5'h0A, 1'b0, 1'b1, 4'h5);
    chk("R6 oe released", 64'(oe), 64'h0);

    // R2: clocks with select high are ignored
    for (int i = 0; i < 16; i++) begin
      din = 1'b1; #20; sclk = 1'b1; #40; sclk = 1'b0; #20;
    end
    #100;
    chk_cfg("R2 outputs kept", 5'h0A, 1'b0, 1'b1, 4'h5);
    xfer(64'h1510, 16);
    chk("R2 shift reg untouched", seen[15:0], 64'h0A25);

    // R7: 20-bit transfer latches the last 16 bits
    xfer(64'hF0A25, 20);
    chk("R7 leading dout", seen[19:4], 64'h1510);
    chk_cfg("R7 last 16 latched", 5'h0A, 1'b0, 1'b1, 4'h5);

    // R7/R5: 32-bit chained transfer
    xfer(64'h1F3F0000, 32);
    chk("R5 chain dout", seen[31:0], 64'h0A251F3F);
    chk_cfg("R7 chain latch", 5'h00, 1'b0, 1'b0, 4'h0);

    // R8: reset during operation
    xfer(64'h1F3F, 16);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_cfg("R8 mid reset", 5'h0, 1'b0, 1'b0, 4'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    xfer(64'h0A25, 16);
    chk("R8 shift reg cleared", seen[15:0], 64'h0);
    chk_cfg("R3 after reset", 5'h0A, 1'b0, 1'b1, 4'h5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule